// File: doc/BRIEF.md
# DMA Bus Error Retry Counter

This block sits beside a DMA engine and decides what to do each time a bus cycle ends in error. The host loads an 8-bit retry budget. While the budget is above zero, each error makes the block ask the engine to reissue the same transfer, and the budget drops by one. Once the budget is exhausted, the next error stops DMA to the failing buffer and raises an interrupt. Both stay in force until the host acknowledges the interrupt. The host may then load a fresh budget.

The engine reports the outcome of every bus cycle with a cycle-complete pulse. An error flag is valid only when it comes with that pulse. The host can write the budget at any time and can read it back on a dedicated output. The retry request is a single-clock pulse. The suspend flag and the interrupt request are level signals that stay high until the acknowledge.

Top module: `dma_berr_retry`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, count is 0x00 and retry_req, suspend and irq are all 0.
- R2: A host write (cnt_wr_en high) makes count equal to cnt_wr_data on the following cycle.
- R3: An accepted error when count is nonzero raises retry_req for exactly the following cycle and lowers count by one. An error is accepted when bus_err and cyc_done are both high and suspend is low.
- R4: An accepted error when count is zero sets suspend and irq on the following cycle, gives no retry_req, and leaves count at zero.
- R5: suspend and irq remain high until a cycle with irq_ack high, and both are low on the cycle after it. An irq_ack while suspend is low changes no output.
- R6: While suspend is high, bus_err with cyc_done gives no retry_req and leaves count unchanged. Host writes still load the count.
- R7: When a host write and an accepted error fall in the same cycle, count takes the written value. The choice between retry and suspend is still made from the count held before that clock edge.
- R8: bus_err without cyc_done, or cyc_done without bus_err, changes neither count nor any output.
- R9: retry_req and suspend are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Host write strobe for the retry budget |
| cnt_wr_data | input | 8 | Value to load into the retry budget |
| bus_err | input | 1 | The bus cycle reported this clock ended in error |
| cyc_done | input | 1 | Pulse marking the end of a DMA bus cycle |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| retry_req | output | 1 | One-clock request to reissue the same transfer |
| suspend | output | 1 | DMA to the failing buffer is halted |
| irq | output | 1 | Interrupt request to the host |
| count | output | 8 | Current retry budget for readback |

## Verification
Two collisions receive the most attention. The first is a host write of the budget in the same cycle as an accepted error: the new count must come from the write, while the retry or suspend choice must follow the old count. The second is an acknowledge that arrives together with an error, where the error must be ignored if the block was already suspended. The bench forces both collisions on purpose, with the budget at zero and at nonzero values. Weighted random traffic then produces many more of them. A reference model in the bench predicts every output on every cycle, and each comparison is tagged with the requirement that its situation exercises.

// File: rtl/dma_berr_pkg.sv
package dma_berr_pkg;

    localparam int unsigned BUDGET_W_DEF = 8;

    // Outcome chosen for the bus cycle that ends this clock
    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_RETRY    = 2'd1,
        ACT_ESCALATE = 2'd2
    } err_act_e;

endpackage

// File: rtl/dma_berr_budget.sv
module dma_berr_budget #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         dec,
    output logic [W-1:0] budget,
    output logic         empty
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } budget_t;

    localparam budget_t RESET_VAL = '{cnt: '0};

    budget_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wr_data;          // host write beats the decrement
        end else if (dec) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    assign budget = st_q.cnt;
    assign empty  = (st_q.cnt == '0);

endmodule

// File: rtl/dma_berr_escalate.sv
module dma_berr_escalate
    import dma_berr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  err_act_e act,
    input  logic     ack,
    output logic     retry,
    output logic     halted,
    output logic     intr
);

    typedef struct packed {
        logic retry;
        logic halted;
        logic intr;
    } flags_t;

    localparam flags_t RESET_VAL = '{retry: 1'b0, halted: 1'b0, intr: 1'b0};

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.retry = (act == ACT_RETRY);
        if (fl_q.halted && ack) begin
            fl_d.halted = 1'b0;
            fl_d.intr   = 1'b0;
        end
        if (act == ACT_ESCALATE) begin
            fl_d.halted = 1'b1;
            fl_d.intr   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= RESET_VAL;
        else        fl_q <= fl_d;
    end

    assign retry  = fl_q.retry;
    assign halted = fl_q.halted;
    assign intr   = fl_q.intr;

endmodule

// File: rtl/dma_berr_retry.sv
module dma_berr_retry
    import dma_berr_pkg::*;
#(
    parameter int unsigned CNT_W = BUDGET_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             bus_err,
    input  logic             cyc_done,
    input  logic             irq_ack,
    output logic             retry_req,
    output logic             suspend,
    output logic             irq,
    output logic [CNT_W-1:0] count
);

    err_act_e act_d;
    logic     budget_empty;
    logic     halted_q;

    // Choose the outcome of the bus cycle that completes this clock
    always_comb begin
        act_d = ACT_NONE;
        if (bus_err && cyc_done && !halted_q) begin
            act_d = budget_empty ? ACT_ESCALATE : ACT_RETRY;
        end
    end

    dma_berr_budget #(.W(CNT_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .dec     (act_d == ACT_RETRY),
        .budget  (count),
        .empty   (budget_empty)
    );

    dma_berr_escalate u_esc (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act_d),
        .ack    (irq_ack),
        .retry  (retry_req),
        .halted (halted_q),
        .intr   (irq)
    );

    assign suspend = halted_q;

endmodule

module dma_berr_retry_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic             bus_err,
    input logic             cyc_done,
    input logic             irq_ack,
    input logic             retry_req,
    input logic             suspend,
    input logic             irq,
    input logic [CNT_W-1:0] count
);

    // R2
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (count == $past(cnt_wr_data)));

    // R3
    retry_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && cyc_done && !suspend && count != '0 && !cnt_wr_en)
        |=> (retry_req && !suspend && count == $past(count) - CNT_W'(1)));

    // R4
    escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && cyc_done && !suspend && count == '0)
        |=> (suspend && irq && !retry_req));

    // R5
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !irq_ack) |=> (suspend && irq));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && irq_ack) |=> (!suspend && !irq));

    // R6
    frozen_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !cnt_wr_en) |=> ($stable(count) && !retry_req));

    // R8
    unqualified_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_err && cyc_done) && !cnt_wr_en) |=> ($stable(count) && !retry_req));

    // R9
    retry_vs_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_req && suspend));

endmodule

bind dma_berr_retry dma_berr_retry_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .bus_err     (bus_err),
    .cyc_done    (cyc_done),
    .irq_ack     (irq_ack),
    .retry_req   (retry_req),
    .suspend     (suspend),
    .irq         (irq),
    .count       (count)
);

// File: tb/dma_berr_retry_tb.sv
module dma_berr_retry_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = 8'h00;
    logic       bus_err = 1'b0;
    logic       cyc_done = 1'b0;
    logic       irq_ack = 1'b0;
    logic       retry_req, suspend, irq;
    logic [7:0] count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0] m_cnt   = 8'h00;
    logic       m_retry = 1'b0;
    logic       m_susp  = 1'b0;
    logic       m_irq   = 1'b0;

    always #5 clk = ~clk;

    dma_berr_retry u_dut (
        .clk (clk), .rst_n (rst_n), .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
        .bus_err (bus_err), .cyc_done (cyc_done), .irq_ack (irq_ack),
        .retry_req (retry_req), .suspend (suspend), .irq (irq), .count (count)
    );

    function automatic string pick_tag(bit rst, bit wr, bit be, bit cd, bit ack,
                                       logic [7:0] c, bit s);
        bit taken = be && cd && !s;
        if (!rst)              return "R1";
        if (wr && taken)       return "R7";
        if (wr)                return "R2";
        if (s && ack)          return "R5";
        if (s && be && cd)     return "R6";
        if (taken && c != 0)   return "R3";
        if (taken)             return "R4";
        if (be != cd)          return "R8";
        if (s)                 return "R5";
        return "R9";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: apply inputs, advance model, compare at next falling edge
    task automatic step(bit rst, bit wr, logic [7:0] wd, bit be, bit cd, bit ack);
        string tag = pick_tag(rst, wr, be, cd, ack, m_cnt, m_susp);
        bit    taken = be && cd && !m_susp;
        rst_n = rst; cnt_wr_en = wr; cnt_wr_data = wd;
        bus_err = be; cyc_done = cd; irq_ack = ack;
        if (!rst) begin
            m_cnt = 0; m_retry = 0; m_susp = 0; m_irq = 0;
        end else begin
            m_retry = taken && (m_cnt != 0);
            if (m_susp && ack) begin m_susp = 0; m_irq = 0; end
            if (taken && m_cnt == 0) begin m_susp = 1; m_irq = 1; end
            if (wr)                      m_cnt = wd;
            else if (taken && m_cnt != 0) m_cnt = m_cnt - 8'd1;
        end
        @(negedge clk);
        check(tag, "count",     int'(count),     int'(m_cnt));
        check(tag, "retry_req", int'(retry_req), int'(m_retry));
        check(tag, "suspend",   int'(suspend),   int'(m_susp));
        check(tag, "irq",       int'(irq),       int'(m_irq));
        // R9: retry and suspend exclusive
        check("R9", "retry&suspend", int'(retry_req && suspend), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_0b1d;
        void'($urandom(seed));
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0);          // R1 in reset
        step(0, 1, 8'h55, 1, 1, 1);      // R1 reset dominates
        step(1, 0, 0, 0, 0, 0);          // R1 first cycle out of reset
        step(1, 1, 8'd2, 0, 0, 0);       // R2 load 2
        step(1, 0, 0, 1, 0, 0);          // R8 error without completion
        step(1, 0, 0, 0, 1, 0);          // R8 completion without error
        step(1, 0, 0, 1, 1, 0);          // R3 retry, 2->1
        step(1, 0, 0, 1, 1, 0);          // R3 back-to-back retry, 1->0
        step(1, 0, 0, 1, 1, 0);          // R4 escalate
        step(1, 0, 0, 0, 0, 0);          // R5 held
        step(1, 0, 0, 1, 1, 0);          // R6 ignored while suspended
        step(1, 1, 8'd4, 0, 0, 0);       // R6 write still loads
        step(1, 0, 0, 1, 1, 1);          // R5 ack with error: error ignored
        step(1, 0, 0, 0, 0, 1);          // R5 ack while idle
        step(1, 1, 8'd9, 1, 1, 0);       // R7 write + retry: count=9
        step(1, 1, 8'd0, 0, 0, 0);       // R2 load 0
        step(1, 1, 8'd7, 1, 1, 0);       // R7 write + escalate from old zero
        step(1, 1, 8'hff, 0, 0, 1);      // R5 ack and write together
        step(1, 0, 0, 1, 1, 0);          // R3 0xff -> 0xfe
        for (int i = 0; i < 4000; i++) begin
            bit wr  = ($urandom % 10) == 0;
            bit be  = ($urandom % 3) == 0;
            bit cd  = ($urandom % 2) == 0;
            bit ack = ($urandom % 6) == 0;
            bit rs  = ($urandom % 500) != 0;
            logic [7:0] wd = (($urandom % 2) == 0) ? 8'($urandom % 4) : 8'($urandom);
            step(rs, wr, wd, be, cd, ack);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule